// File: doc/BRIEF.md
# Layered RGB Compositor with Range Keying

This block merges several pixel-aligned RGB layer streams into one output stream. There are four overlay planes plus a cursor plane, and all arrive on the same clock. Each layer carries a presence flag, three 12-bit channels and an 8-bit alpha. The compositor starts from a black background. It lays the planes on from bottom to top in a fixed order: plane 0 first, then planes 1 to 3, and the cursor last. Each plane is mixed over everything beneath it in proportion to its alpha.

Any plane can be keyed against one shared inclusive min/max window per channel. In source mode, a plane pixel that lies inside the window becomes transparent. In destination mode, the plane shows only where the result built up below it lies inside the window. All mixing is done at 12 bits per channel. The final result is rounded and saturated to 8 bits per channel. Configuration inputs (enables, alphas, key selection, window) are expected to be held steady while pixels flow. Pixel data and the stream flags are pipelined with a fixed latency of two cycles.

Top module: `layer_mixer`

## Requirements
- R1: While rst_ni is low, valid_o, sol_o, sof_o and rgb_o are all zero.
- R2: A pixel and its valid_i, sol_i and sof_i flags sampled at a rising edge appear on rgb_o, valid_o, sol_o and sof_o right after the next rising edge, a latency of two edges. Consecutive pixels stay in order.
- R3: Layer k occupies lyr_rgb_i[k*36 +: 36], with R in bits [35:24], G in [23:12] and B in [11:0]. Its alpha occupies lyr_alpha_i[k*8 +: 8]. Index 4 is the cursor. Stacking starts from black (all zero) and applies index 0 first and the cursor last.
- R4: Each layer step computes, per channel, s = a*top + (255-a)*bottom + 128 and result = (s + (s>>8)) >> 8, kept to 12 bits.
- R5: An alpha of 255 replaces the lower result with the layer pixel exactly. An alpha of 0 leaves the lower result unchanged.
- R6: A layer whose lyr_en_i bit is low, or whose lyr_vld_i bit is low, is skipped as if its alpha were 0.
- R7: With the layer's key_en_i bit set and key_dst_i low (source mode), a layer pixel whose R, G and B all lie inside the key window is skipped. If any one channel lies outside the window, the layer blends normally.
- R8: With the layer's key_en_i bit set and key_dst_i high (destination mode), the layer blends only when the lower accumulated result lies inside the window on all three channels. Otherwise it is skipped.
- R9: The window bounds key_lo_i and key_hi_i are inclusive, with the same channel packing as R3. A channel whose low bound is greater than its high bound matches no value.
- R10: Each 12-bit channel v is reduced to min(255, (v+8)>>4). rgb_o carries R in [23:16], G in [15:8] and B in [7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Stream pixel valid |
| sol_i | input | 1 | First pixel of a line |
| sof_i | input | 1 | First pixel of a frame |
| lyr_vld_i | input | 5 | Per-layer presence for this pixel |
| lyr_rgb_i | input | 180 | Per-layer 36-bit RGB |
| lyr_alpha_i | input | 40 | Per-layer 8-bit alpha |
| lyr_en_i | input | 5 | Per-layer enable |
| key_en_i | input | 5 | Per-layer keying enable |
| key_dst_i | input | 1 | 0 selects source keying, 1 selects destination keying |
| key_lo_i | input | 36 | Inclusive lower window bound per channel |
| key_hi_i | input | 36 | Inclusive upper window bound per channel |
| valid_o | output | 1 | Output pixel valid |
| sol_o | output | 1 | Output line start |
| sof_o | output | 1 | Output frame start |
| rgb_o | output | 24 | Composited 8-bit-per-channel pixel |

## Verification
The bench builds the default parameters: four overlays plus the cursor, 12-bit channels, 8-bit alpha and 8-bit output. With these values, a full-scale 12-bit channel rounds past 255, so saturation can be reached. Mid-scale alpha values give blend results whose expected values can be worked out by hand from the shift formula. Every stacking position is present, including a keyed cursor. Window edges are placed on exact channel values to probe inclusivity and empty windows.

// File: rtl/mix_pkg.sv
package mix_pkg;
  localparam int unsigned N_CH = 3;
  typedef enum logic {KEY_SRC = 1'b0, KEY_DST = 1'b1} key_mode_e;
endpackage

// File: rtl/mix_range_match.sv
module mix_range_match
  import mix_pkg::*;
#(
  parameter int unsigned CW = 12
) (
  input  logic [N_CH*CW-1:0] pix_i,
  input  logic [N_CH*CW-1:0] lo_i,
  input  logic [N_CH*CW-1:0] hi_i,
  output logic               hit_o
);
  logic [N_CH-1:0] in_ch;

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    assign in_ch[ch] = (pix_i[ch*CW +: CW] >= lo_i[ch*CW +: CW]) &&
                       (pix_i[ch*CW +: CW] <= hi_i[ch*CW +: CW]);
  end

  assign hit_o = &in_ch;
endmodule

// File: rtl/mix_blend_step.sv
module mix_blend_step
  import mix_pkg::*;
#(
  parameter int unsigned CW = 12,
  parameter int unsigned AW = 8
) (
  input  logic [N_CH*CW-1:0] top_i,
  input  logic [N_CH*CW-1:0] bot_i,
  input  logic [AW-1:0]      alpha_i,
  input  logic               use_i,
  input  logic               key_en_i,
  input  key_mode_e          key_mode_i,
  input  logic [N_CH*CW-1:0] key_lo_i,
  input  logic [N_CH*CW-1:0] key_hi_i,
  output logic               keyed_o,
  output logic [N_CH*CW-1:0] out_o
);
  localparam int unsigned PW   = CW + AW + 1;
  localparam int unsigned HALF = 1 << (AW - 1);

  logic [N_CH*CW-1:0] cmp_pix;
  logic               hit;
  logic [AW-1:0]      a_eff;
  logic [AW-1:0]      a_inv;

  // destination mode tests what lies underneath
  assign cmp_pix = (key_mode_i == KEY_DST) ? bot_i : top_i;

  mix_range_match #(.CW(CW)) i_match (
    .pix_i (cmp_pix),
    .lo_i  (key_lo_i),
    .hi_i  (key_hi_i),
    .hit_o (hit)
  );

  assign keyed_o = use_i && key_en_i && ((key_mode_i == KEY_SRC) ? hit : !hit);
  assign a_eff   = (use_i && !keyed_o) ? alpha_i : '0;
  assign a_inv   = ~a_eff;

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    logic [PW-1:0] s;
    logic [PW-1:0] y;
    assign s = PW'(a_eff) * PW'(top_i[ch*CW +: CW])
             + PW'(a_inv) * PW'(bot_i[ch*CW +: CW])
             + PW'(HALF);
    // divide by 2^AW-1 via shift-and-add
    assign y = (s + (s >> AW)) >> AW;
    assign out_o[ch*CW +: CW] = y[CW-1:0];
  end
endmodule

// File: rtl/mix_narrow.sv
module mix_narrow
  import mix_pkg::*;
#(
  parameter int unsigned CW = 12,
  parameter int unsigned OW = 8
) (
  input  logic [N_CH*CW-1:0] wide_i,
  output logic [N_CH*OW-1:0] narrow_o
);
  localparam int unsigned SH = CW - OW;

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    logic [CW:0] r;
    logic [OW:0] q;
    assign r = {1'b0, wide_i[ch*CW +: CW]} + (CW+1)'(1 << (SH - 1));
    assign q = r[CW:SH];
    assign narrow_o[ch*OW +: OW] = q[OW] ? {OW{1'b1}} : q[OW-1:0];
  end
endmodule

// File: rtl/layer_mixer.sv
module layer_mixer
  import mix_pkg::*;
#(
  parameter int unsigned N_OVL = 4,
  parameter int unsigned CW    = 12,
  parameter int unsigned AW    = 8,
  parameter int unsigned OW    = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        valid_i,
  input  logic                        sol_i,
  input  logic                        sof_i,
  input  logic [N_OVL:0]              lyr_vld_i,
  input  logic [(N_OVL+1)*3*CW-1:0]   lyr_rgb_i,
  input  logic [(N_OVL+1)*AW-1:0]     lyr_alpha_i,
  input  logic [N_OVL:0]              lyr_en_i,
  input  logic [N_OVL:0]              key_en_i,
  input  logic                        key_dst_i,
  input  logic [3*CW-1:0]             key_lo_i,
  input  logic [3*CW-1:0]             key_hi_i,
  output logic                        valid_o,
  output logic                        sol_o,
  output logic                        sof_o,
  output logic [3*OW-1:0]             rgb_o
);
  localparam int unsigned NL   = N_OVL + 1;
  localparam int unsigned PXW  = N_CH * CW;
  localparam int unsigned AMAX = (1 << AW) - 1;

  logic              valid_q, sol_q, sof_q;
  logic [NL-1:0]     vld_q;
  logic [NL*PXW-1:0] rgb_q;
  logic [PXW-1:0]    acc [NL+1];
  logic [NL-1:0]     keyed;
  logic [N_CH*OW-1:0] fin;
  logic              empty_rng;

  // stage 1: capture pixel data
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      sol_q   <= 1'b0;
      sof_q   <= 1'b0;
      vld_q   <= '0;
      rgb_q   <= '0;
    end else begin
      valid_q <= valid_i;
      sol_q   <= sol_i;
      sof_q   <= sof_i;
      vld_q   <= lyr_vld_i;
      rgb_q   <= lyr_rgb_i;
    end
  end

  assign acc[0] = '0;

  for (genvar k = 0; k < NL; k++) begin : g_lyr
    mix_blend_step #(.CW(CW), .AW(AW)) i_step (
      .top_i      (rgb_q[k*PXW +: PXW]),
      .bot_i      (acc[k]),
      .alpha_i    (lyr_alpha_i[k*AW +: AW]),
      .use_i      (lyr_en_i[k] && vld_q[k]),
      .key_en_i   (key_en_i[k]),
      .key_mode_i (key_mode_e'(key_dst_i)),
      .key_lo_i   (key_lo_i),
      .key_hi_i   (key_hi_i),
      .keyed_o    (keyed[k]),
      .out_o      (acc[k+1])
    );

    p_skip_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!lyr_en_i[k] || !vld_q[k]) |-> acc[k+1] == acc[k]);

    p_opaque_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lyr_en_i[k] && vld_q[k] && !keyed[k] && lyr_alpha_i[k*AW +: AW] == AW'(AMAX))
      |-> acc[k+1] == rgb_q[k*PXW +: PXW]);

    p_keyed_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      keyed[k] |-> acc[k+1] == acc[k]);

    p_empty_range_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (empty_rng && !key_dst_i) |-> !keyed[k]);
  end

  always_comb begin
    empty_rng = 1'b0;
    for (int ch = 0; ch < N_CH; ch++) begin
      if (key_lo_i[ch*CW +: CW] > key_hi_i[ch*CW +: CW]) empty_rng = 1'b1;
    end
  end

  mix_narrow #(.CW(CW), .OW(OW)) i_narrow (
    .wide_i   (acc[NL]),
    .narrow_o (fin)
  );

  // stage 2: output register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      sol_o   <= 1'b0;
      sof_o   <= 1'b0;
      rgb_o   <= '0;
    end else begin
      valid_o <= valid_q;
      sol_o   <= sol_q;
      sof_o   <= sof_q;
      rgb_o   <= fin;
    end
  end

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_sat
    p_sat_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (&acc[NL][ch*CW+CW-OW-1 +: OW+1]) |=> rgb_o[ch*OW +: OW] == {OW{1'b1}});
  end

  p_valid_lat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> ##2 valid_o);
  p_idle_lat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> ##2 !valid_o);
  p_sof_lat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_i |-> ##2 sof_o);
endmodule

// File: tb/test_layer_mixer.sv
`timescale 1ns/1ps
module test_layer_mixer;
  typedef struct packed {
    logic [4:0][35:0] rgb;
    logic [4:0][7:0]  a;
    logic [4:0]       en;
    logic [4:0]       vld;
    logic [4:0]       ken;
    logic             kdst;
    logic [35:0]      lo;
    logic [35:0]      hi;
    logic [23:0]      exp;
    logic [3:0]       req;
  } vec_t;

  function automatic logic [35:0] c(input logic [11:0] r, g, b);
    return {r, g, b};
  endfunction

  localparam logic [35:0] Z = 36'h0;
  localparam int NV = 13;
  localparam vec_t VT [NV] = '{
    // R10 base only, saturating blue
    '{ {Z, Z, Z, Z, c(12'h800, 12'h400, 12'hFFF)}, 40'h00000000FF, 5'b00001, 5'b11111,
       5'b0, 1'b0, Z, Z, 24'h8040FF, 4'd10 },
    // R3 cursor on top of all
    '{ {c(12'h123, 12'h456, 12'h789), c(12'h111, 12'h111, 12'h111), c(12'h222, 12'h222, 12'h222),
        c(12'h333, 12'h333, 12'h333), c(12'h444, 12'h444, 12'h444)}, 40'hFFFFFFFFFF, 5'b11111, 5'b11111,
       5'b0, 1'b0, Z, Z, 24'h124579, 4'd3 },
    // R6 cursor disabled, L3 shows
    '{ {c(12'hFFF, 12'hFFF, 12'hFFF), c(12'hAB8, 12'h0F7, 12'h300), c(12'h555, 12'h555, 12'h555), Z, Z},
       40'hFFFFFFFFFF, 5'b01111, 5'b11111, 5'b0, 1'b0, Z, Z, 24'hAC0F30, 4'd6 },
    // R6 absent layers skipped
    '{ {c(12'hFFF, 12'hFFF, 12'hFFF), c(12'hEEE, 12'hEEE, 12'hEEE), c(12'h5A0, 12'h5A0, 12'h5A0),
        c(12'h111, 12'h111, 12'h111), c(12'h222, 12'h222, 12'h222)}, 40'hFFFFFFFFFF, 5'b11111, 5'b00111,
       5'b0, 1'b0, Z, Z, 24'h5A5A5A, 4'd6 },
    // R5 alpha zero leaves base
    '{ {Z, Z, Z, c(12'hFFF, 12'hFFF, 12'hFFF), c(12'h200, 12'h300, 12'h400)}, 40'h00000000FF, 5'b00011,
       5'b11111, 5'b0, 1'b0, Z, Z, 24'h203040, 4'd5 },
    // R4 mid alpha blend
    '{ {Z, Z, Z, c(12'h000, 12'hFFF, 12'h800), c(12'hFFF, 12'h000, 12'h800)}, 40'h00000080FF, 5'b00011,
       5'b11111, 5'b0, 1'b0, Z, Z, 24'h7F8180, 4'd4 },
    // R7 source key hit (inclusive edges)
    '{ {Z, Z, Z, c(12'h7F0, 12'h7F0, 12'h7F0), c(12'h100, 12'h200, 12'h300)}, 40'h000000FFFF, 5'b00011,
       5'b11111, 5'b00010, 1'b0, c(12'h7F0, 12'h700, 12'h7F0), c(12'h7F0, 12'h800, 12'h7FF), 24'h102030, 4'd7 },
    // R7 one channel outside
    '{ {Z, Z, Z, c(12'h7F0, 12'h7F0, 12'h7F0), c(12'h100, 12'h200, 12'h300)}, 40'h000000FFFF, 5'b00011,
       5'b11111, 5'b00010, 1'b0, c(12'h7F1, 12'h700, 12'h7F0), c(12'h7F0, 12'h800, 12'h7FF), 24'h7F7F7F, 4'd7 },
    // R8 destination key inside
    '{ {Z, Z, Z, c(12'hE00, 12'hE00, 12'hE00), c(12'h100, 12'h100, 12'h100)}, 40'h000000FFFF, 5'b00011,
       5'b11111, 5'b00010, 1'b1, c(12'h0F8, 12'h0F8, 12'h0F8), c(12'h108, 12'h108, 12'h108), 24'hE0E0E0, 4'd8 },
    // R8 destination key outside
    '{ {Z, Z, Z, c(12'hE00, 12'hE00, 12'hE00), c(12'h100, 12'h100, 12'h200)}, 40'h000000FFFF, 5'b00011,
       5'b11111, 5'b00010, 1'b1, c(12'h0F8, 12'h0F8, 12'h0F8), c(12'h108, 12'h108, 12'h108), 24'h101020, 4'd8 },
    // R9 empty window never matches
    '{ {Z, Z, Z, c(12'h780, 12'h780, 12'h780), Z}, 40'h000000FFFF, 5'b00011, 5'b11111, 5'b00010, 1'b0,
       c(12'h800, 12'h800, 12'h800), c(12'h700, 12'h700, 12'h700), 24'h787878, 4'd9 },
    // R3 black background under half alpha
    '{ {Z, Z, Z, c(12'hFFF, 12'hFFF, 12'hFFF), Z}, 40'h0000008000, 5'b00010, 5'b11111, 5'b0, 1'b0,
       Z, Z, 24'h818181, 4'd3 },
    // R7 keyed cursor
    '{ {Z, Z, Z, Z, c(12'h300, 12'h300, 12'h300)}, 40'hFF000000FF, 5'b10001, 5'b11111, 5'b10000, 1'b0,
       Z, Z, 24'h303030, 4'd7 }
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid = 1'b0, sol = 1'b0, sof = 1'b0;
  logic [4:0]   lyr_vld = '0, lyr_en = '0, key_en = '0;
  logic [179:0] lyr_rgb = '0;
  logic [39:0]  lyr_alpha = '0;
  logic         key_dst = 1'b0;
  logic [35:0]  key_lo = '0, key_hi = '0;
  logic         valid_o, sol_o, sof_o;
  logic [23:0]  rgb_o;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  layer_mixer i_layer_mixer (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .sol_i(sol), .sof_i(sof),
    .lyr_vld_i(lyr_vld), .lyr_rgb_i(lyr_rgb), .lyr_alpha_i(lyr_alpha), .lyr_en_i(lyr_en),
    .key_en_i(key_en), .key_dst_i(key_dst), .key_lo_i(key_lo), .key_hi_i(key_hi),
    .valid_o(valid_o), .sol_o(sol_o), .sof_o(sof_o), .rgb_o(rgb_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1", {7'b0, valid_o, sol_o, sof_o, rgb_o}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      lyr_rgb = VT[i].rgb; lyr_alpha = VT[i].a; lyr_en = VT[i].en; lyr_vld = VT[i].vld;
      key_en = VT[i].ken; key_dst = VT[i].kdst; key_lo = VT[i].lo; key_hi = VT[i].hi;
      valid = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk($sformatf("R%0d vec%0d", VT[i].req, i), {8'b0, rgb_o}, {8'b0, VT[i].exp});
    end

    // R2 latency and flag alignment
    valid = 1'b0;
    lyr_en = 5'b00001; lyr_vld = 5'b11111; lyr_alpha = 40'hFF; key_en = '0;
    repeat (3) @(negedge clk);
    valid = 1'b1; sol = 1'b1; sof = 1'b1; lyr_rgb = {144'b0, c(12'h100, 12'h100, 12'h100)};
    @(negedge clk);
    chk("R2 not yet", {31'b0, valid_o}, 32'h0);
    valid = 1'b1; sol = 1'b0; sof = 1'b0; lyr_rgb = {144'b0, c(12'h200, 12'h200, 12'h200)};
    @(negedge clk);
    chk("R2 first", {5'b0, valid_o, sol_o, sof_o, rgb_o}, {5'b0, 3'b111, 24'h101010});
    valid = 1'b0;
    @(negedge clk);
    chk("R2 second", {5'b0, valid_o, sol_o, sof_o, rgb_o}, {5'b0, 3'b100, 24'h202020});
    @(negedge clk);
    chk("R2 drained", {31'b0, valid_o}, 32'h0);

    // R1 reset mid-stream clears outputs
    valid = 1'b1; sof = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 async", {7'b0, valid_o, sol_o, sof_o, rgb_o}, 32'h0);

    done = 1'b1;
    finish_run();
  end
endmodule